// File: doc/BRIEF.md
# Audio Master Clock Divider

This block sits between an audio converter's master clock and its serial port. A three-bit strap code picks the clocking arrangement. In the master arrangements the block divides the master clock down to a bit clock at 64 times the sample rate and a frame clock at the sample rate. In the slave arrangements it only reports that the port clocks come from outside, and it drives its own clock outputs low. The master flag can serve as the output enable for the bidirectional clock pins.

The four master codes select master-clock-to-sample-rate ratios of 256, 384, 512 and 768. That gives 2, 3, 4 or 6 master-clock cycles per bit-clock half period. A frame spans 64 bit-clock periods. The frame clock is high for the first 32 of them (the left half) and low for the last 32, and it only moves when the bit clock falls. The active-low power-down input resets both dividers at once, without waiting for a clock. After power-down is released, or after the code changes to a master code, both dividers restart in phase, so the first frame starts with a full left half.

Top module: `audio_mclk_divider`

## Requirements
- R1: Codes 3'b010, 3'b110, 3'b011 and 3'b111 are master modes with 2, 3, 4 and 6 master-clock cycles per bit-clock half period. For each of them `master_o` is 1. The three flags decode `sel_i` combinationally, whatever the state of `pwr_n_i`.
- R2: Codes 3'b000 (CMOS levels) and 3'b100 (TTL levels) are slave modes. In both, `master_o` is 0. `ttl_o` is 1 only for 3'b100. Under any non-master code, both clock outputs are low from the first master-clock edge after the code is applied.
- R3: Codes 3'b001 and 3'b101 are reserved. They set `rsvd_o` to 1, clear `master_o` and hold both clocks low. At most one of the three flags is 1 at any time.
- R4: In a master mode, `bclk_o` has a period of 2·H master-clock cycles and is high for H of them, where H is the half period from R1.
- R5: One frame lasts 64 bit-clock periods. `fclk_o` is 1 for the first 32 bit-clock periods (left half) and 0 for the last 32.
- R6: While running, `fclk_o` changes only on a master-clock edge where `bclk_o` falls.
- R7: While `pwr_n_i` is 0, both clock outputs are 0. Asserting `pwr_n_i` low forces them to 0 at once, without waiting for a clock edge.
- R8: After `pwr_n_i` rises, or after `sel_i` changes value, both clocks are low after the first master-clock edge. If the code is a master code, `fclk_o` rises with `bclk_o` low on the second edge, and a full left half begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock |
| pwr_n_i | input | 1 | Power-down, active low; also resets the dividers |
| sel_i | input | 3 | Clocking mode strap code |
| fclk_o | output | 1 | Frame clock: one period per sample, high for the left half |
| bclk_o | output | 1 | Bit clock at 64 times the frame rate |
| master_o | output | 1 | 1 when the code selects master mode |
| ttl_o | output | 1 | 1 when the code selects slave mode with TTL input levels |
| rsvd_o | output | 1 | 1 when the code is reserved |

## Verification
Each of the four master ratios is run for a complete frame. Counting bit-clock high cycles, bit-clock rising edges and frame-clock high cycles separates a wrong divide ratio from a wrong duty or a wrong frame length. The code is also switched between ratios while running, and power-down is pulsed mid-frame. These show whether the two dividers restart together and whether the first frame begins with a full left half. Each slave code and each reserved code is held long enough to show that no clock edge escapes and that exactly the right flag is set.

// File: rtl/amck_pkg.sv
package amck_pkg;
    localparam int unsigned HALF_W = 3;

    typedef enum logic [1:0] {
        PIN_SLAVE_CMOS = 2'd0,
        PIN_SLAVE_TTL  = 2'd1,
        PIN_MASTER     = 2'd2,
        PIN_RESERVED   = 2'd3
    } pin_kind_e;

    typedef struct packed {
        pin_kind_e         kind;
        logic [HALF_W-1:0] half;
    } pin_mode_t;
endpackage

// File: rtl/amck_mode_dec.sv
module amck_mode_dec
    import amck_pkg::*;
#(
    parameter int unsigned HALF_256 = 2,
    parameter int unsigned HALF_384 = 3,
    parameter int unsigned HALF_512 = 4,
    parameter int unsigned HALF_768 = 6
) (
    input  logic [2:0] sel_i,
    output pin_mode_t  mode_o
);
    always_comb begin
        mode_o.kind = PIN_RESERVED;
        mode_o.half = '0;
        case (sel_i)
            3'b000: mode_o.kind = PIN_SLAVE_CMOS;
            3'b100: mode_o.kind = PIN_SLAVE_TTL;
            3'b010: begin mode_o.kind = PIN_MASTER; mode_o.half = HALF_W'(HALF_256); end
            3'b110: begin mode_o.kind = PIN_MASTER; mode_o.half = HALF_W'(HALF_384); end
            3'b011: begin mode_o.kind = PIN_MASTER; mode_o.half = HALF_W'(HALF_512); end
            3'b111: begin mode_o.kind = PIN_MASTER; mode_o.half = HALF_W'(HALF_768); end
            default: mode_o.kind = PIN_RESERVED;
        endcase
    end
endmodule

// File: rtl/amck_clk_gen.sv
module amck_clk_gen
    import amck_pkg::*;
#(
    parameter int unsigned FRAME_BCLKS = 64
) (
    input  logic              mclk_i,
    input  logic              pwr_n_i,
    input  logic              run_en_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic [2:0]        sel_i,
    output logic              bclk_o,
    output logic              fclk_o
);
    localparam int unsigned    CNT_W = $clog2(FRAME_BCLKS);
    localparam logic [CNT_W-1:0] MID = CNT_W'(FRAME_BCLKS / 2);

    typedef struct packed {
        logic              run;
        logic [2:0]        tag;
        logic [HALF_W-1:0] div;
        logic              bclk;
        logic [CNT_W-1:0]  bitn;
        logic              fclk;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    last_mclk;

    assign last_mclk = (st_q.div >= (half_i - HALF_W'(1)));

    always_comb begin
        st_d = st_q;
        if (!run_en_i || (sel_i != st_q.tag)) begin
            st_d     = '0;
            st_d.tag = sel_i;
        end else if (!st_q.run) begin
            st_d.run  = 1'b1;
            st_d.fclk = 1'b1;
            st_d.bclk = 1'b0;
            st_d.div  = '0;
            st_d.bitn = '0;
        end else if (last_mclk) begin
            st_d.div  = '0;
            st_d.bclk = ~st_q.bclk;
            if (st_q.bclk) begin
                st_d.bitn = st_q.bitn + CNT_W'(1);
                if (st_d.bitn == MID) begin
                    st_d.fclk = 1'b0;
                end else if (st_d.bitn == '0) begin
                    st_d.fclk = 1'b1;
                end
            end
        end else begin
            st_d.div = st_q.div + HALF_W'(1);
        end
    end

    always_ff @(posedge mclk_i or negedge pwr_n_i) begin
        if (!pwr_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;
    assign fclk_o = st_q.fclk;

    assert_fclk_on_bclk_fall_R6: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
        (st_q.run && $past(st_q.run) && (st_q.fclk != $past(st_q.fclk))) |-> $fell(st_q.bclk));

    assert_idle_clocks_low_R2: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
        !run_en_i |=> (!bclk_o && !fclk_o));

    assert_bclk_hold_R4: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
        (st_q.run && run_en_i && (sel_i == st_q.tag) && !last_mclk) |=> $stable(bclk_o));

    assert_start_left_half_R8: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
        $rose(st_q.run) |-> (fclk_o && !bclk_o));
endmodule

// File: rtl/audio_mclk_divider.sv
module audio_mclk_divider
    import amck_pkg::*;
#(
    parameter int unsigned FRAME_BCLKS = 64,
    parameter int unsigned HALF_256    = 2,
    parameter int unsigned HALF_384    = 3,
    parameter int unsigned HALF_512    = 4,
    parameter int unsigned HALF_768    = 6
) (
    input  logic       mclk_i,
    input  logic       pwr_n_i,
    input  logic [2:0] sel_i,
    output logic       fclk_o,
    output logic       bclk_o,
    output logic       master_o,
    output logic       ttl_o,
    output logic       rsvd_o
);
    pin_mode_t mode;

    amck_mode_dec #(
        .HALF_256(HALF_256),
        .HALF_384(HALF_384),
        .HALF_512(HALF_512),
        .HALF_768(HALF_768)
    ) i_dec (
        .sel_i (sel_i),
        .mode_o(mode)
    );

    assign master_o = (mode.kind == PIN_MASTER);
    assign ttl_o    = (mode.kind == PIN_SLAVE_TTL);
    assign rsvd_o   = (mode.kind == PIN_RESERVED);

    amck_clk_gen #(
        .FRAME_BCLKS(FRAME_BCLKS)
    ) i_gen (
        .mclk_i  (mclk_i),
        .pwr_n_i (pwr_n_i),
        .run_en_i(master_o),
        .half_i  (mode.half),
        .sel_i   (sel_i),
        .bclk_o  (bclk_o),
        .fclk_o  (fclk_o)
    );

    assert_flags_exclusive_R3: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
        $onehot0({master_o, ttl_o, rsvd_o}));
endmodule

// File: tb/test_audio_mclk_divider.sv
module test_audio_mclk_divider;
    localparam int CLK_PERIOD = 10;

    logic       mclk  = 1'b0;
    logic       pwr_n = 1'b0;
    logic [2:0] sel   = 3'b010;
    logic       fclk, bclk, master, ttl, rsvd;

    int total = 0;
    int bad   = 0;

    audio_mclk_divider i_audio_mclk_divider (
        .mclk_i  (mclk),
        .pwr_n_i (pwr_n),
        .sel_i   (sel),
        .fclk_o  (fclk),
        .bclk_o  (bclk),
        .master_o(master),
        .ttl_o   (ttl),
        .rsvd_o  (rsvd)
    );

    always #(CLK_PERIOD/2) mclk = ~mclk;

    function automatic int half_of(input logic [2:0] s);
        case (s)
            3'b010: return 2;
            3'b110: return 3;
            3'b011: return 4;
            3'b111: return 6;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model: time since the current frame sequence started
    int m_run = 0;
    int m_tag = 0;
    int m_t   = 0;

    always @(posedge mclk) begin
        if (!pwr_n) begin
            m_run = 0;
            m_tag = 0;
        end else if (half_of(sel) == 0 || int'(sel) != m_tag) begin
            m_run = 0;
            m_tag = int'(sel);
        end else if (m_run == 0) begin
            m_run = 1;
            m_t   = 0;
        end else begin
            m_t++;
        end
    end

    always @(negedge mclk) begin
        int h, eb, ef;
        h  = half_of(m_tag[2:0]);
        eb = 0;
        ef = 0;
        if (m_run != 0 && h != 0) begin
            eb = (m_t / h) % 2;
            ef = (((m_t / (2*h)) % 64) < 32) ? 1 : 0;
        end
        chk("R4 bclk per cycle", int'(bclk), eb);
        chk("R5 fclk per cycle", int'(fclk), ef);
        chk("R1 master flag", int'(master), (half_of(sel) != 0) ? 1 : 0);
        chk("R2 ttl flag", int'(ttl), (sel == 3'b100) ? 1 : 0);
        chk("R3 reserved flag", int'(rsvd), (sel == 3'b001 || sel == 3'b101) ? 1 : 0);
    end

    task automatic step(input int n);
        repeat (n) @(negedge mclk);
    endtask

    task automatic measure(input int h);
        int fh = 0, bh = 0, br = 0;
        logic pb;
        pb = bclk;
        for (int i = 0; i < 128*h; i++) begin
            if (fclk) fh++;
            if (bclk) bh++;
            if (bclk && !pb) br++;
            pb = bclk;
            step(1);
        end
        chk("R4 bclk high cycles per frame", bh, 64*h);
        chk("R4 bclk rising edges per frame", br, 64);
        chk("R5 fclk high cycles per frame", fh, 64*h);
        chk("R5 next frame starts high", int'(fclk), 1);
        chk("R5 next frame bclk low", int'(bclk), 0);
    endtask

    task automatic run_master(input logic [2:0] code, input int h);
        #1 sel = code;
        step(1);
        chk("R8 first edge clears fclk", int'(fclk), 0);
        chk("R8 first edge clears bclk", int'(bclk), 0);
        step(1);
        chk("R8 second edge fclk high", int'(fclk), 1);
        chk("R8 second edge bclk low", int'(bclk), 0);
        measure(h);
    endtask

    task automatic hold_idle(input logic [2:0] code, input string req);
        int hi = 0;
        #1 sel = code;
        step(1);
        for (int i = 0; i < 40; i++) begin
            if (bclk || fclk) hi++;
            step(1);
        end
        chk(req, hi, 0);
    endtask

    initial begin
        step(3);
        chk("R7 reset bclk low", int'(bclk), 0);
        chk("R7 reset fclk low", int'(fclk), 0);
        chk("R1 flag during power-down", int'(master), 1);
        #1 pwr_n = 1'b1;
        step(1);
        chk("R8 release first edge fclk", int'(fclk), 0);
        step(1);
        chk("R8 release second edge fclk", int'(fclk), 1);
        chk("R8 release second edge bclk", int'(bclk), 0);
        measure(2);
        run_master(3'b110, 3);
        run_master(3'b011, 4);
        run_master(3'b111, 6);
        chk("R7 fclk high before power-down", int'(fclk), 1);
        #1 pwr_n = 1'b0;
        #1;
        chk("R7 async clear bclk", int'(bclk), 0);
        chk("R7 async clear fclk", int'(fclk), 0);
        step(4);
        chk("R7 held low fclk", int'(fclk), 0);
        #1 pwr_n = 1'b1;
        step(2);
        chk("R8 restart after power-down", int'(fclk), 1);
        step(50);
        hold_idle(3'b000, "R2 cmos slave clocks quiet");
        hold_idle(3'b100, "R2 ttl slave clocks quiet");
        hold_idle(3'b001, "R3 reserved 001 clocks quiet");
        hold_idle(3'b101, "R3 reserved 101 clocks quiet");
        run_master(3'b010, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule